// File: doc/BRIEF.md
# Mains Period Tracking Loop

This block keeps a free-running timer phase- and frequency-locked to the mains supply. The timer period is steered so that six timer periods fill one line cycle, and a timer boundary falls on the falling zero crossing of the line voltage. A squared copy of the line voltage enters on `zc_i`. It passes through a flop synchroniser and a falling-edge detector. On each falling edge the current counter value is captured.

The capture is compared with a target phase. The error is wrapped into half a reference period on either side and scaled down by an arithmetic right shift. It is then added to the reference period. The sum is clamped to a window around the reference and becomes the pending period. The timer adopts the pending period at its next wrap.

Two event strobes leave the block so that downstream logic can tell them apart. One marks each counter wrap, and a pulse generator can use it to time its pulses. The other marks each zero-crossing capture.

Top module: `mains_period_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following values are forced after that edge: `cnt_o` is 0, `period_o` and `next_period_o` are REF_PERIOD, `cap_value_o` is 0, and both strobes are 0.
- R2: `cnt_o` counts 0, 1, … up to `period_o`−1 and then returns to 0. `wrap_evt_o` is high for exactly the one cycle in which `cnt_o` has just returned to 0. The spacing between wrap strobes therefore equals `period_o`.
- R3: If `zc_i` is first sampled low at edge k after being high, then `cap_value_o` takes the `cnt_o` value present between edges k+1 and k+2. `cap_evt_o` is high for the single cycle after edge k+2.
- R4: A rising edge on `zc_i`, or a level held steady, causes no capture. `cap_evt_o` stays 0 and `cap_value_o` keeps its value.
- R5: Let HALF be REF_PERIOD/2, rounded down. The phase error is the capture minus TARGET_PHASE. If the error is at least HALF, the current `period_o` is subtracted from it. If it is below −HALF, `period_o` is added to it.
- R6: The unclamped pending period is REF_PERIOD plus the error shifted right arithmetically by ERR_SHIFT. The shift rounds toward minus infinity.
- R7: The pending period is clamped to the range from REF_PERIOD − (REF_PERIOD>>CLAMP_SHIFT) to REF_PERIOD + (REF_PERIOD>>CLAMP_SHIFT).
- R8: `next_period_o` changes only together with `cap_evt_o`. `period_o` changes only on a wrap, and on a wrap it takes the `next_period_o` value held just before that wrap.
- R9: The wrap strobe and the capture strobe are independent and may be high in the same cycle. No two captures occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_i | input | 1 | Squared line voltage, asynchronous |
| cnt_o | output | CNT_W | Free-running counter value |
| period_o | output | CNT_W | Period in use by the counter |
| next_period_o | output | CNT_W | Corrected period, adopted at the next wrap |
| cap_value_o | output | CNT_W | Counter value captured at the last falling crossing |
| wrap_evt_o | output | 1 | One-cycle strobe on each counter wrap |
| cap_evt_o | output | 1 | One-cycle strobe on each capture |

## Verification
A wrong sign, shift or wrap decision in the error path shows up on `next_period_o` in the cycle of the capture strobe. The value in use, `period_o`, shows it at the next wrap, and the spacing between wrap strobes shows it one period later. A fault in the synchroniser depth moves `cap_value_o` by one count at the first capture. A counter that loads the pending period at the wrong moment breaks the wrap spacing within one timer period.

// File: rtl/mpl_pkg.sv
// Shared types for the mains period tracking loop.
// Assumes: single clock domain after the input synchroniser.
package mpl_pkg;
    // Event strobes raised by the loop, one bit per source.
    typedef struct packed {
        logic wrap;   // counter returned to zero
        logic cap;    // zero crossing captured
    } mpl_evt_t;
endpackage

// File: rtl/mpl_zc_sync.sv
// Zero-crossing input conditioner: a chain of STAGES flops followed by a
// falling-edge detector.
// Assumes: STAGES >= 2. The chain resets low, so a line that is already high
// at reset release is seen as a rising edge and starts no capture.
module mpl_zc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first sampling flop on the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= zc_i;
                end
            end else begin : g_next
                // Purpose: further resolution stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Purpose: remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    // Purpose: a high-to-low step on the synchronised level is a falling crossing.
    always_comb fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/mpl_timer.sv
// Free-running period counter. It counts 0..period-1 and adopts the pending
// period only at the wrap, so a period change never cuts a cycle short.
// Assumes: next_period_i >= 2.
module mpl_timer #(
    parameter int CNT_W      = 16,
    parameter int REF_PERIOD = 3333
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] period_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] REF_V = CNT_W'(REF_PERIOD);

    logic at_end;

    // Purpose: detect the last count of the current period.
    always_comb at_end = (cnt_o == period_o - CNT_W'(1));

    // Purpose: advance the counter, and on the wrap load the pending period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o    <= '0;
            period_o <= REF_V;
            wrap_o   <= 1'b0;
        end else if (at_end) begin
            cnt_o    <= '0;
            period_o <= next_period_i;
            wrap_o   <= 1'b1;
        end else begin
            cnt_o    <= cnt_o + CNT_W'(1);
            wrap_o   <= 1'b0;
        end
    end
endmodule

// File: rtl/mpl_period_calc.sv
// Capture and correction path. On a falling crossing it stores the counter
// value, forms the wrapped signed phase error, scales it with an arithmetic
// shift, adds the reference period and clamps the result.
// Assumes: the reference period plus its clamp margin fits in CNT_W bits.
module mpl_period_calc #(
    parameter int CNT_W        = 16,
    parameter int REF_PERIOD   = 3333,
    parameter int TARGET_PHASE = 0,
    parameter int ERR_SHIFT    = 3,
    parameter int CLAMP_SHIFT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             cap_evt_o,
    output logic [CNT_W-1:0] next_o
);
    localparam int EW     = CNT_W + 2;
    localparam int HALF   = REF_PERIOD / 2;
    localparam int MARGIN = REF_PERIOD >> CLAMP_SHIFT;
    localparam logic signed [EW-1:0] REF_S  = EW'(REF_PERIOD);
    localparam logic signed [EW-1:0] TGT_S  = EW'(TARGET_PHASE);
    localparam logic signed [EW-1:0] HALF_S = EW'(HALF);
    localparam logic signed [EW-1:0] LO_S   = EW'(REF_PERIOD - MARGIN);
    localparam logic signed [EW-1:0] HI_S   = EW'(REF_PERIOD + MARGIN);

    logic signed [EW-1:0] raw_err;
    logic signed [EW-1:0] err;
    logic signed [EW-1:0] corr;
    logic signed [EW-1:0] sum;
    logic [CNT_W-1:0]     clamped;

    // Purpose: raw phase error of the counter value against the target.
    always_comb raw_err = $signed({2'b00, cnt_i}) - TGT_S;

    // Purpose: fold the error into the half-period window around the target.
    always_comb begin
        if (raw_err >= HALF_S)
            err = raw_err - $signed({2'b00, period_i});
        else if (raw_err < -HALF_S)
            err = raw_err + $signed({2'b00, period_i});
        else
            err = raw_err;
    end

    // Purpose: scale the error and add it to the reference period.
    always_comb begin
        corr = err >>> ERR_SHIFT;
        sum  = REF_S + corr;
    end

    // Purpose: keep the corrected period inside the allowed window.
    always_comb begin
        if (sum < LO_S)      clamped = LO_S[CNT_W-1:0];
        else if (sum > HI_S) clamped = HI_S[CNT_W-1:0];
        else                 clamped = sum[CNT_W-1:0];
    end

    // Purpose: register capture, pending period and capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_o     <= '0;
            next_o    <= CNT_W'(REF_PERIOD);
            cap_evt_o <= 1'b0;
        end else begin
            cap_evt_o <= fall_i;
            if (fall_i) begin
                cap_o  <= cnt_i;
                next_o <= clamped;
            end
        end
    end
endmodule

// File: rtl/mains_period_lock.sv
// Top of the mains period tracking loop: input conditioner, period counter
// and correction path. The pending period feeds back into the counter, and
// the counter value feeds forward into the capture.
// Assumes: clk is the timer tick (1 MHz by default sizing) and zc_i is a
// clean square wave whose falling edge marks the line crossing.
module mains_period_lock
    import mpl_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int REF_PERIOD   = 3333,
    parameter int TARGET_PHASE = 0,
    parameter int ERR_SHIFT    = 3,
    parameter int CLAMP_SHIFT  = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] next_period_o,
    output logic [CNT_W-1:0] cap_value_o,
    output logic             wrap_evt_o,
    output logic             cap_evt_o
);
    mpl_evt_t   evt;
    logic       zc_fall;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] next_w;

    mpl_zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .zc_i   (zc_i),
        .fall_o (zc_fall)
    );

    mpl_timer #(.CNT_W(CNT_W), .REF_PERIOD(REF_PERIOD)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .next_period_i (next_w),
        .cnt_o         (cnt_w),
        .period_o      (period_w),
        .wrap_o        (evt.wrap)
    );

    mpl_period_calc #(
        .CNT_W        (CNT_W),
        .REF_PERIOD   (REF_PERIOD),
        .TARGET_PHASE (TARGET_PHASE),
        .ERR_SHIFT    (ERR_SHIFT),
        .CLAMP_SHIFT  (CLAMP_SHIFT)
    ) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (zc_fall),
        .cnt_i     (cnt_w),
        .period_i  (period_w),
        .cap_o     (cap_value_o),
        .cap_evt_o (evt.cap),
        .next_o    (next_w)
    );

    // Purpose: drive the block outputs from the internal nets.
    always_comb begin
        cnt_o         = cnt_w;
        period_o      = period_w;
        next_period_o = next_w;
        wrap_evt_o    = evt.wrap;
        cap_evt_o     = evt.cap;
    end
endmodule

// File: rtl/mpl_checker.sv
// Property checker for the mains period tracking loop, bound to the top.
module mpl_checker #(
    parameter int CNT_W       = 16,
    parameter int REF_PERIOD  = 3333,
    parameter int CLAMP_SHIFT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] next_period_o,
    input logic [CNT_W-1:0] cap_value_o,
    input logic             wrap_evt_o,
    input logic             cap_evt_o
);
    localparam int MARGIN = REF_PERIOD >> CLAMP_SHIFT;
    localparam logic [CNT_W-1:0] LO_V  = CNT_W'(REF_PERIOD - MARGIN);
    localparam logic [CNT_W-1:0] HI_V  = CNT_W'(REF_PERIOD + MARGIN);
    localparam logic [CNT_W-1:0] REF_V = CNT_W'(REF_PERIOD);

    a_r1_reset_state: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (cnt_o == '0 && period_o == REF_V &&
                              next_period_o == REF_V && !wrap_evt_o && !cap_evt_o));

    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o < period_o);

    a_r2_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt_o |-> (cnt_o == '0));

    a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_o |-> (cap_value_o == $past(cnt_o)));

    a_r4_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt_o |-> $stable(cap_value_o));

    a_r7_next_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (next_period_o >= LO_V) && (next_period_o <= HI_V));

    a_r8_next_only_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt_o |-> $stable(next_period_o));

    a_r8_period_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_evt_o |-> $stable(period_o));

    a_r8_period_loads_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt_o |-> (period_o == $past(next_period_o)));

    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_o |=> !cap_evt_o);
endmodule

bind mains_period_lock mpl_checker #(
    .CNT_W       (CNT_W),
    .REF_PERIOD  (REF_PERIOD),
    .CLAMP_SHIFT (CLAMP_SHIFT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_o         (cnt_o),
    .period_o      (period_o),
    .next_period_o (next_period_o),
    .cap_value_o   (cap_value_o),
    .wrap_evt_o    (wrap_evt_o),
    .cap_evt_o     (cap_evt_o)
);

// File: tb/tb_mains_period_lock.sv
module tb_mains_period_lock;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW  = 16;
    localparam int REF = 100;
    localparam int SH  = 1;
    localparam int CS  = 3;
    localparam int NV  = 9;
    // Capture target and the pending period expected for it (REF 100,
    // target 0, shift 1, window 88..112), in chained order.
    localparam int VEC_C [NV] = '{16, 0, 95, 49, 104, 60, 30, 2, 100};
    localparam int VEC_P [NV] = '{108, 100, 97, 112, 96, 88, 112, 101, 99};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zc = 1'b1;
    logic [CW-1:0] cnt, per, nxt, capv;
    logic wrap_evt, cap_evt;

    int checks = 0;
    int errors = 0;

    mains_period_lock #(
        .CNT_W(CW), .REF_PERIOD(REF), .TARGET_PHASE(0),
        .ERR_SHIFT(SH), .CLAMP_SHIFT(CS), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .zc_i(zc),
        .cnt_o(cnt), .period_o(per), .next_period_o(nxt),
        .cap_value_o(capv), .wrap_evt_o(wrap_evt), .cap_evt_o(cap_evt)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int old_p;
        int caps_seen;
        int n;
        int tgt;
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(cnt == 0, "R1 cnt", cnt, 0);
        chk(per == REF && nxt == REF, "R1 period", per, REF);
        chk(!wrap_evt && !cap_evt && capv == 0, "R1 strobes", {wrap_evt, cap_evt}, 0);
        rst_n = 1'b1;

        // R4: input already high rises through the synchroniser, no capture
        caps_seen = 0;
        repeat (10) begin
            @(negedge clk);
            if (cap_evt) caps_seen++;
        end
        chk(caps_seen == 0 && capv == 0, "R4 rising no capture", caps_seen, 0);

        // R2: wrap spacing at reset period
        n = 0;
        while (!wrap_evt && n < 1000) begin @(negedge clk); n++; end
        chk(cnt == 0, "R2 wrap at zero", cnt, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!wrap_evt && n < 1000);
        chk(n == REF, "R2 wrap spacing", n, REF);

        // Vector walk: aim each capture, check capture, pending and adoption
        for (int i = 0; i < NV; i++) begin
            tgt = (VEC_C[i] >= 2) ? VEC_C[i] - 2 : int'(per) + VEC_C[i] - 2;
            n = 0;
            while (int'(cnt) != tgt && n < 1000) begin @(negedge clk); n++; end
            old_p = per;
            zc = 1'b0;
            repeat (3) @(negedge clk);
            chk(cap_evt == 1'b1, "R3 capture strobe", cap_evt, 1);
            chk(capv == VEC_C[i], "R3 capture value", capv, VEC_C[i]);
            chk(nxt == VEC_P[i], "R5/R6/R7 pending period", nxt, VEC_P[i]);
            chk(per == old_p, "R8 period held until wrap", per, old_p);
            if (VEC_C[i] == old_p - 1)
                chk(wrap_evt == 1'b1, "R9 wrap with capture", wrap_evt, 1);
            zc = 1'b1;
            caps_seen = 0;
            n = 0;
            do begin
                @(negedge clk); n++;
                if (cap_evt) caps_seen++;
            end while (!wrap_evt && n < 1000);
            chk(per == VEC_P[i], "R8 period adopted at wrap", per, VEC_P[i]);
            n = 0;
            do begin
                @(negedge clk); n++;
                if (cap_evt) caps_seen++;
            end while (!wrap_evt && n < 1000);
            chk(n == VEC_P[i], "R2 spacing after update", n, VEC_P[i]);
            chk(caps_seen == 0, "R4 no capture on rise or level", caps_seen, 0);
        end

        // R1: reset mid-run restores the reference state
        rst_n = 1'b0;
        @(negedge clk);
        chk(per == REF && nxt == REF && cnt == 0, "R1 reset again", per, REF);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule